// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a single-slope PWM timer with one period register and a parameterised number of channels. Each channel works either as a compare channel or as a capture channel. The period register and every compare register each have a shadow buffer in front of them. Software writes new values into the buffers while the waveform is running. A pending value moves into its active register only at an update, which happens when the counter reaches the period. This keeps every PWM cycle free of glitches. Software can also write the active registers directly, and such a write takes effect at once.

Each buffer has a pending flag. A buffer write sets the flag. Software can drop a pending value by writing a one to the flag's position. An update that consumes the value also clears the flag. A lock control, with one address to set it and another to clear it, holds every pending value back across updates. A capture channel ignores its buffer. It latches the counter on a rising edge of its capture input and raises its flag until software reads the captured value.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset the counter, the period, all compare/capture registers, all buffers, all pending flags, the run bit, the lock bit and the mode bits are zero, and every output is low.
- R2: Writing a channel buffer (address 8+NUM_CH+ch) in compare mode stores the value, which reads back at that address, and sets that channel's pending flag (status address 3, bit ch+1).
- R3: Writing status address 3 with a one in bit 0 clears the period pending flag, and a one in bit ch+1 clears the flag of compare channel ch. The dropped value is not transferred at later updates. Zero bits have no effect.
- R4: Writing the period buffer (address 7) sets the period pending flag (status bit 0), and the next unlocked update moves the value into the active period (address 6).
- R5: While running, the counter (address 4) steps by one each cycle. When it equals the active period, `upd_pulse` is high for exactly that one cycle and the counter restarts from zero.
- R6: At an update with the lock clear, every pending buffer copies into its active register in the same cycle and its flag clears. A buffer written in the update cycle keeps its new value pending, while the older value is transferred.
- R7: With the run bit (control address 0, bit 0) low, the counter holds its value, `upd_pulse` stays low and no buffer is transferred.
- R8: When the counter and the active period are both zero, no update is generated and the counter stays at zero even though the timer runs.
- R9: A write to the active period (address 6) or to an active channel register (address 8+ch) takes effect in the next cycle, whether the timer is stopped or running.
- R10: Writing a one in bit 0 to address 1 sets the lock, and writing a one to address 2 clears it. The lock reads back at control bit 1. While the lock is set, updates still occur but transfer nothing, and flags stay set. After the lock clears, the next update transfers.
- R11: The output `pwm_out[ch]` is high while the channel is in compare mode and the counter is below its active compare value. It is low otherwise, and always low in capture mode.
- R12: With mode bit ch (address 5) set, a rising edge on `cap_in[ch]` stores the current counter value into register 8+ch and sets flag ch+1. Reading address 8+ch with `rd_en` clears that flag. Buffer writes to a capture channel change neither the buffer nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Read strobe; marks a read that has side effects |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data for `rd_addr`, combinational from register state |
| cap_in | input | NUM_CH | Capture inputs, rising-edge sensitive |
| pwm_out | output | NUM_CH | Channel waveform outputs |
| upd_pulse | output | 1 | One-cycle pulse on each update condition |

## Verification
The bench builds the block with an 8-bit counter and four channels. The narrow counter lets a run with a zero period wrap back to zero within a few hundred cycles, which makes the zero-period hold reachable. Four channels allow one channel in capture mode while the others exercise compare transfers, cancelled buffers and locked buffers side by side. The bench also times a buffer write to land exactly in an update cycle.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // Register addresses; channel blocks follow from ADR_CC_BASE.
  localparam int ADR_CTRL     = 0;
  localparam int ADR_LOCK_SET = 1;
  localparam int ADR_LOCK_CLR = 2;
  localparam int ADR_STATUS   = 3;
  localparam int ADR_COUNT    = 4;
  localparam int ADR_MODE     = 5;
  localparam int ADR_PER      = 6;
  localparam int ADR_PER_BUF  = 7;
  localparam int ADR_CC_BASE  = 8;

  function automatic int adr_cc_buf_base(input int num_ch);
    return ADR_CC_BASE + num_ch;
  endfunction

  // Per-slot control strobes decoded from the register bus.
  typedef struct packed {
    logic wr_act;  // direct write of the active register
    logic wr_buf;  // write of the shadow buffer
    logic w1c;     // drop pending value
    logic rd_act;  // side-effect read of the active register
  } slot_ctl_t;

endpackage

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] count,
  output logic             update_evt
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             zero_hold;

  // Counter and period both zero: no update, counter parked.
  assign zero_hold  = (count_q == '0) && (per == '0);
  assign update_evt = run && (count_q == per) && !zero_hold;

  always_comb begin
    count_en = run;
    count_d  = count_q;
    if (update_evt || zero_hold) begin
      count_d = '0;
    end else begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/pwm_dbuf_slot.sv
module pwm_dbuf_slot
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  slot_ctl_t ctl,
  input  logic [W-1:0] wdata,
  input  logic      cap_mode,
  input  logic      cap_evt,
  input  logic [W-1:0] cap_val,
  input  logic      xfer,
  output logic [W-1:0] act_val,
  output logic [W-1:0] buf_val,
  output logic      pending
);

  logic [W-1:0] act_q, act_d;
  logic [W-1:0] buf_q, buf_d;
  logic         vld_q, vld_d;
  logic         act_en, buf_en, vld_en;
  logic         take;

  // Transfer only consumes a value that is actually pending.
  assign take = xfer && vld_q && !cap_mode;

  always_comb begin
    act_d  = act_q;
    buf_d  = buf_q;
    vld_d  = vld_q;
    act_en = 1'b0;
    buf_en = 1'b0;
    vld_en = 1'b0;
    if (cap_mode) begin
      if (cap_evt) begin
        act_d  = cap_val;
        act_en = 1'b1;
        vld_d  = 1'b1;
        vld_en = 1'b1;
      end else begin
        if (ctl.wr_act) begin
          act_d  = wdata;
          act_en = 1'b1;
        end
        if (ctl.rd_act) begin
          vld_d  = 1'b0;
          vld_en = 1'b1;
        end
      end
    end else begin
      if (take) begin
        act_d  = buf_q;
        act_en = 1'b1;
      end else if (ctl.wr_act) begin
        act_d  = wdata;
        act_en = 1'b1;
      end
      if (ctl.wr_buf) begin
        buf_d  = wdata;
        buf_en = 1'b1;
        vld_d  = 1'b1;
        vld_en = 1'b1;
      end else if (ctl.w1c || take) begin
        vld_d  = 1'b0;
        vld_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else if (vld_en) begin
      vld_q <= vld_d;
    end
  end

  assign act_val = act_q;
  assign buf_val = buf_q;
  assign pending = vld_q;

endmodule

// File: rtl/pwm_dbuf_regif.sv
module pwm_dbuf_regif
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [NUM_CH:0]              wr_low,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [CNT_W-1:0]             count,
  input  logic [CNT_W-1:0]             per_act,
  input  logic [CNT_W-1:0]             per_buf,
  input  logic                         per_pend,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cc_act,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cc_buf,
  input  logic [NUM_CH-1:0]            cc_pend,
  output logic                         run,
  output logic                         lock,
  output logic [NUM_CH-1:0]            cap_mode,
  output slot_ctl_t                    per_ctl,
  output slot_ctl_t [NUM_CH-1:0]       cc_ctl,
  output logic [CNT_W-1:0]             rd_data
);

  localparam int CCB_BASE = adr_cc_buf_base(NUM_CH);

  logic              hit_ctrl, hit_lset, hit_lclr, hit_stat, hit_mode;
  logic              run_q, run_d, run_en;
  logic              lock_q, lock_d, lock_en;
  logic [NUM_CH-1:0] mode_q, mode_d;
  logic              mode_en;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign hit_lset = wr_en && (wr_addr == ADDR_W'(ADR_LOCK_SET));
  assign hit_lclr = wr_en && (wr_addr == ADDR_W'(ADR_LOCK_CLR));
  assign hit_stat = wr_en && (wr_addr == ADDR_W'(ADR_STATUS));
  assign hit_mode = wr_en && (wr_addr == ADDR_W'(ADR_MODE));

  // Period slot strobes
  assign per_ctl.wr_act = wr_en && (wr_addr == ADDR_W'(ADR_PER));
  assign per_ctl.wr_buf = wr_en && (wr_addr == ADDR_W'(ADR_PER_BUF));
  assign per_ctl.w1c    = hit_stat && wr_low[0];
  assign per_ctl.rd_act = 1'b0;

  // Channel slot strobes
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_dec
    assign cc_ctl[i].wr_act = wr_en && (wr_addr == ADDR_W'(ADR_CC_BASE + i));
    assign cc_ctl[i].wr_buf = wr_en && (wr_addr == ADDR_W'(CCB_BASE + i));
    assign cc_ctl[i].w1c    = hit_stat && wr_low[i+1];
    assign cc_ctl[i].rd_act = rd_en && (rd_addr == ADDR_W'(ADR_CC_BASE + i));
  end

  // Control state next-state logic
  always_comb begin
    run_en  = hit_ctrl;
    run_d   = wr_low[0];
    lock_en = (hit_lset || hit_lclr) && wr_low[0];
    lock_d  = hit_lset;
    mode_en = hit_mode;
    mode_d  = wr_low[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign run      = run_q;
  assign lock     = lock_q;
  assign cap_mode = mode_q;

  // Read multiplexer
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(ADR_CTRL):    rd_data = CNT_W'({lock_q, run_q});
      ADDR_W'(ADR_STATUS):  rd_data = CNT_W'({cc_pend, per_pend});
      ADDR_W'(ADR_COUNT):   rd_data = count;
      ADDR_W'(ADR_MODE):    rd_data = CNT_W'(mode_q);
      ADDR_W'(ADR_PER):     rd_data = per_act;
      ADDR_W'(ADR_PER_BUF): rd_data = per_buf;
      default:              rd_data = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(ADR_CC_BASE + i)) rd_data = cc_act[i];
      if (rd_addr == ADDR_W'(CCB_BASE + i))    rd_data = cc_buf[i];
    end
  end

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] cap_in,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              upd_pulse
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic                         run, lock;
  logic [NUM_CH-1:0]            cap_mode;
  logic [CNT_W-1:0]             count;
  logic                         update_evt;
  logic                         xfer;
  logic [CNT_W-1:0]             per_act, per_buf;
  logic                         per_pend;
  logic [NUM_CH-1:0][CNT_W-1:0] cc_act, cc_buf;
  logic [NUM_CH-1:0]            cc_pend;
  slot_ctl_t                    per_ctl;
  slot_ctl_t [NUM_CH-1:0]       cc_ctl;
  logic [NUM_CH-1:0]            cap_prev;
  logic [NUM_CH-1:0]            cap_edge;

  assign xfer = update_evt && !lock;

  // Capture edge detection
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_prev <= '0;
    end else begin
      cap_prev <= cap_in;
    end
  end

  assign cap_edge = cap_in & ~cap_prev;

  pwm_dbuf_regif #(
    .CNT_W (CNT_W),
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
  ) u_regif (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_low  (wr_data[NUM_CH:0]),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .count   (count),
    .per_act (per_act),
    .per_buf (per_buf),
    .per_pend(per_pend),
    .cc_act  (cc_act),
    .cc_buf  (cc_buf),
    .cc_pend (cc_pend),
    .run     (run),
    .lock    (lock),
    .cap_mode(cap_mode),
    .per_ctl (per_ctl),
    .cc_ctl  (cc_ctl),
    .rd_data (rd_data)
  );

  pwm_dbuf_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .run       (run),
    .per       (per_act),
    .count     (count),
    .update_evt(update_evt)
  );

  pwm_dbuf_slot #(
    .W(CNT_W)
  ) u_per_slot (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ctl     (per_ctl),
    .wdata   (wr_data),
    .cap_mode(1'b0),
    .cap_evt (1'b0),
    .cap_val ('0),
    .xfer    (xfer),
    .act_val (per_act),
    .buf_val (per_buf),
    .pending (per_pend)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_dbuf_slot #(
      .W(CNT_W)
    ) u_cc_slot (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .ctl     (cc_ctl[i]),
      .wdata   (wr_data),
      .cap_mode(cap_mode[i]),
      .cap_evt (cap_edge[i]),
      .cap_val (count),
      .xfer    (xfer),
      .act_val (cc_act[i]),
      .buf_val (cc_buf[i]),
      .pending (cc_pend[i])
    );

    assign pwm_out[i] = !cap_mode[i] && (count < cc_act[i]);
  end

  assign upd_pulse = update_evt;

endmodule

// File: rtl/pwm_dbuf_checker.sv
module pwm_dbuf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             run,
  input logic             lock,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] per_buf,
  input logic             per_pend,
  input logic             upd_pulse
);

  // R5: an update lasts a single cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_pulse |=> !upd_pulse);

  // R5: the counter restarts after an update
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_pulse |=> (count == '0));

  // R7: stopped timer holds its counter
  assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> (count == $past(count)));

  // R7: stopped timer raises no update
  assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |-> !upd_pulse);

  // R8: zero counter with zero period never updates
  assert_zero_period_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    ((count == '0) && (per_act == '0)) |-> !upd_pulse);

  // R6: unlocked update loads the pending period
  assert_period_xfer_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_pulse && !lock && per_pend) |=> (per_act == $past(per_buf)));

endmodule

bind pwm_dbuf_timer pwm_dbuf_checker #(
  .CNT_W(CNT_W)
) u_checker (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .run      (run),
  .lock     (lock),
  .count    (count),
  .per_act  (per_act),
  .per_buf  (per_buf),
  .per_pend (per_pend),
  .upd_pulse(upd_pulse)
);

// File: tb/pwm_dbuf_timer_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_bench;

  localparam int CW = 8;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int MASK = (1 << CW) - 1;
  // addresses
  localparam int A_CTRL = 0, A_LSET = 1, A_LCLR = 2, A_STAT = 3, A_CNT = 4,
                 A_MODE = 5, A_PER = 6, A_PERB = 7, A_CC = 8, A_CCB = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [NC-1:0] cap_in = '0;
  logic [NC-1:0] pwm_out;
  logic          upd_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_dbuf_timer #(.CNT_W(CW), .NUM_CH(NC), .ADDR_W(AW)) u_pwm_dbuf_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
    .pwm_out(pwm_out), .upd_pulse(upd_pulse)
  );

  // Behavioural reference state
  int m_cnt, m_per, m_perb;
  bit m_perv, m_run, m_lock;
  int m_cc[NC];
  int m_ccb[NC];
  bit m_ccv[NC];
  bit m_mode[NC];
  bit m_prev[NC];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_per = 0; m_perb = 0; m_perv = 0; m_run = 0; m_lock = 0;
    for (int i = 0; i < NC; i++) begin
      m_cc[i] = 0; m_ccb[i] = 0; m_ccv[i] = 0; m_mode[i] = 0; m_prev[i] = 0;
    end
  endtask

  function automatic bit m_evt();
    return m_run && (m_cnt == m_per) && !(m_cnt == 0 && m_per == 0);
  endfunction

  task automatic model_step();
    bit evt, xfer, hold, w;
    int n_cnt, n_per, n_perb;
    bit n_perv, n_run, n_lock;
    int n_cc[NC];
    int n_ccb[NC];
    bit n_ccv[NC];
    bit n_mode[NC];
    int a, d;
    w = wr_en; a = int'(wr_addr); d = int'(wr_data);
    hold = (m_cnt == 0 && m_per == 0);
    evt  = m_evt();
    xfer = evt && !m_lock;
    if (!m_run) n_cnt = m_cnt;
    else if (evt || hold) n_cnt = 0;
    else n_cnt = (m_cnt + 1) & MASK;
    n_per = m_per; n_perb = m_perb; n_perv = m_perv;
    if (xfer && m_perv) n_per = m_perb;
    else if (w && a == A_PER) n_per = d;
    if (w && a == A_PERB) begin n_perb = d; n_perv = 1; end
    else if ((w && a == A_STAT && d[0]) || (xfer && m_perv)) n_perv = 0;
    for (int i = 0; i < NC; i++) begin
      n_cc[i] = m_cc[i]; n_ccb[i] = m_ccb[i]; n_ccv[i] = m_ccv[i];
      if (m_mode[i]) begin
        if (cap_in[i] && !m_prev[i]) begin
          n_cc[i] = m_cnt; n_ccv[i] = 1;
        end else begin
          if (w && a == A_CC + i) n_cc[i] = d;
          if (rd_en && int'(rd_addr) == A_CC + i) n_ccv[i] = 0;
        end
      end else begin
        if (xfer && m_ccv[i]) n_cc[i] = m_ccb[i];
        else if (w && a == A_CC + i) n_cc[i] = d;
        if (w && a == A_CCB + i) begin n_ccb[i] = d; n_ccv[i] = 1; end
        else if ((w && a == A_STAT && d[i+1]) || (xfer && m_ccv[i])) n_ccv[i] = 0;
      end
      n_mode[i] = (w && a == A_MODE) ? d[i] : m_mode[i];
    end
    n_run  = (w && a == A_CTRL) ? d[0] : m_run;
    n_lock = m_lock;
    if (w && a == A_LSET && d[0]) n_lock = 1;
    if (w && a == A_LCLR && d[0]) n_lock = 0;
    m_cnt = n_cnt; m_per = n_per; m_perb = n_perb; m_perv = n_perv;
    m_run = n_run; m_lock = n_lock;
    for (int i = 0; i < NC; i++) begin
      m_cc[i] = n_cc[i]; m_ccb[i] = n_ccb[i]; m_ccv[i] = n_ccv[i];
      m_mode[i] = n_mode[i]; m_prev[i] = cap_in[i];
    end
  endtask

  function automatic int m_read(input int a);
    int v;
    v = 0;
    case (a)
      A_CTRL: v = {m_lock, m_run};
      A_STAT: begin
        v = m_perv;
        for (int i = 0; i < NC; i++) v |= int'(m_ccv[i]) << (i + 1);
      end
      A_CNT:  v = m_cnt;
      A_MODE: for (int i = 0; i < NC; i++) v |= int'(m_mode[i]) << i;
      A_PER:  v = m_per;
      A_PERB: v = m_perb;
      default: begin
        if (a >= A_CC && a < A_CC + NC) v = m_cc[a - A_CC];
        if (a >= A_CCB && a < A_CCB + NC) v = m_ccb[a - A_CCB];
      end
    endcase
    return v;
  endfunction

  // Lock-step reference: advance on each edge, compare just after it
  initial model_reset();
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #1;
    if (!done) begin
      for (int i = 0; i < NC; i++)
        chk("R11 pwm_out", int'(pwm_out[i]), int'(!m_mode[i] && (m_cnt < m_cc[i])));
      chk("R5 upd_pulse", int'(upd_pulse), int'(m_evt()));
      chk("R9 rd_data", int'(rd_data), m_read(int'(rd_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_addr = AW'(a); rd_en = 1'b1;
    #1;
    chk(tag, int'(rd_data), exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, ev, snap;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    rd_chk(A_STAT, 0, "R1 status");
    rd_chk(A_CNT, 0, "R1 count");
    rd_chk(A_CTRL, 0, "R1 ctrl");
    chk("R1 outputs", int'({pwm_out, upd_pulse}), 0);

    // R9 direct writes while stopped
    wr(A_PER, 5); wr(A_CC + 0, 2); wr(A_CC + 1, 5);
    rd_chk(A_PER, 5, "R9 period direct");
    rd_chk(A_CC + 1, 5, "R9 cc1 direct");

    // R4 / R2 buffered writes
    wr(A_PERB, 9);
    rd_chk(A_STAT, 1, "R4 period flag");
    wr(A_CCB + 0, 7);
    rd_chk(A_STAT, 3, "R2 ch0 flag");
    rd_chk(A_CCB + 0, 7, "R2 buffer readback");

    // R7 stopped: nothing moves
    idle(10);
    rd_chk(A_PER, 5, "R7 no transfer stopped");
    rd_chk(A_CNT, 0, "R7 count held");

    // R5 / R6 run to first update
    wr(A_CTRL, 1);
    idle(12);
    rd_chk(A_PER, 9, "R4 period transferred");
    rd_chk(A_CC + 0, 7, "R6 cc0 transferred");
    rd_chk(A_STAT, 0, "R6 flags cleared");

    // R3 write-one-to-clear
    wr(A_CCB + 1, 3);
    wr(A_STAT, 4);
    rd_chk(A_STAT, 0, "R3 flag dropped");
    idle(25);
    rd_chk(A_CC + 1, 5, "R3 dropped value not moved");

    // R11 duty over one full period (10 cycles, cc1 = 5)
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      hi += int'(pwm_out[1]);
    end
    chk("R11 duty ch1", hi, 5);

    // R10 lock
    wr(A_LSET, 1);
    rd_chk(A_CTRL, 3, "R10 lock set");
    wr(A_CCB + 2, 4);
    idle(25);
    rd_chk(A_CC + 2, 0, "R10 locked no transfer");
    rd_chk(A_STAT, 8, "R10 flag kept");
    wr(A_LCLR, 1);
    rd_chk(A_CTRL, 1, "R10 lock cleared");
    idle(15);
    rd_chk(A_CC + 2, 4, "R10 transfer after unlock");
    rd_chk(A_STAT, 0, "R10 flag cleared");

    // R6 buffer write landing in the update cycle
    wr(A_CCB + 0, 6);
    while (m_cnt != m_per) @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(A_CCB + 0); wr_data = CW'(1);
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk(A_CC + 0, 6, "R6 old value transferred");
    rd_chk(A_STAT, 2, "R6 new value pending");
    idle(15);
    rd_chk(A_CC + 0, 1, "R6 new value later");

    // R12 capture on channel 3
    wr(A_MODE, 8);
    @(negedge clk); cap_in = 4'b1000;
    @(negedge clk); cap_in = 4'b0000;
    rd_chk(A_STAT, 16, "R12 capture flag");
    snap = m_cc[3];
    rd_chk(A_CC + 3, snap, "R12 captured count");
    rd_chk(A_STAT, 0, "R12 read clears flag");
    wr(A_CCB + 3, 85);
    rd_chk(A_STAT, 0, "R12 buffer write no flag");
    rd_chk(A_CCB + 3, 0, "R12 buffer unchanged");
    chk("R11 capture output low", int'(pwm_out[3]), 0);

    // R8 zero period
    wr(A_CTRL, 0);
    wr(A_PER, 0);
    wr(A_CTRL, 1);
    idle(300);
    rd_chk(A_CNT, 0, "R8 counter parked");
    ev = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      ev += int'(upd_pulse);
    end
    chk("R8 no update", ev, 0);

    // R9 direct write while running, R5 pulse rate
    wr(A_PER, 3);
    rd_chk(A_PER, 3, "R9 period direct running");
    ev = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ev += int'(upd_pulse);
    end
    chk("R5 pulses per 8 cycles", ev, 2);

    // R7 stop mid-run
    wr(A_CTRL, 0);
    snap = m_cnt;
    rd_chk(A_CNT, snap, "R7 count at stop");
    idle(10);
    rd_chk(A_CNT, snap, "R7 count still held");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule